// File: doc/BRIEF.md
# Dual-Memory Multiply-Accumulate Datapath

This block is the arithmetic heart of a signal-processing core. In a single issued operation it fetches one 16-bit operand from an X data memory and one from a separate Y data memory, multiplies them as signed values and adds the product into one of two 40-bit accumulators. Both memory addresses come from a bank of eight 8-bit address registers, and both registers used may be stepped forward by one in the same operation. That one operation replaces a load/store sequence of two loads, a multiply and three additions.

The datapath has two stages. In the issue cycle the two selected address registers drive the memory address ports, and the synchronous memories return data on the next clock edge. The second stage multiplies the returned words and updates the accumulator. The 40-bit accumulators keep eight guard bits above the 32-bit product. On overflow they either wrap or, when the operation asks for it, clamp to the signed limits. Further operations clear an accumulator, load an address register from an immediate, and multiply-accumulate without stepping the address registers.

Top module: `dmac_core`

## Requirements
- R1: After reset all eight address registers and both accumulators read as zero.
- R2: `x_addr` always shows the address register chosen by `op_ari`, and `y_addr` shows the one chosen by `op_arj`, whatever the operation code.
- R3: Operation code 1 (post-stepping multiply-accumulate) adds the signed 16x16 product of the X and Y words at the two presented addresses into the accumulator chosen by `op_acc` (0 = A, 1 = B). The new value is visible after the second rising edge from issue, and the other accumulator keeps its value.
- R4: Operation code 1 adds one to both selected address registers at the issue edge, wrapping from 255 to 0.
- R5: When `op_ari` equals `op_arj` under operation code 1, that register advances by exactly one.
- R6: Operation code 2 accumulates like code 1 but leaves every address register unchanged.
- R7: Multiply-accumulates issued on consecutive cycles to the same accumulator each add their own product.
- R8: Operation code 3 zeroes the accumulator chosen by `op_acc` after any earlier-issued accumulations have landed, and it leaves the other accumulator unchanged.
- R9: Operation code 4 writes `op_imm` into the address register chosen by `op_ari` at the issue edge, so the next operation already sees it. Codes 0, 5, 6 and 7 change nothing.
- R10: With `op_sat` low, an accumulation that leaves the 40-bit signed range wraps modulo 2^40.
- R11: With `op_sat` high, an accumulation that would overflow holds the accumulator at 2^39-1, or at -2^39 in the negative direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Operation: 0 none, 1 MAC with step, 2 MAC without step, 3 clear, 4 load address |
| op_ari | input | 3 | Address register for X (also the load target) |
| op_arj | input | 3 | Address register for Y |
| op_acc | input | 1 | Accumulator select, 0 = A, 1 = B |
| op_imm | input | 8 | Immediate for address load |
| op_sat | input | 1 | Saturate instead of wrap for this operation |
| x_addr | output | 8 | X memory read address |
| y_addr | output | 8 | Y memory read address |
| x_rdata | input | 16 | X memory data, one cycle after address |
| y_rdata | input | 16 | Y memory data, one cycle after address |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |

## Verification
A long stream of stepping multiply-accumulates walks two registers through all 256 addresses and past the wrap point. The accumulator select alternates along the way, which separates a correct pipeline from one that adds stale data, drops a back-to-back product or writes the wrong accumulator. Runs with both operands on one register, and runs without stepping, tell single stepping apart from double stepping and from no stepping at all. Several hundred maximum-magnitude products, positive and negative, drive the accumulators past their range with and without saturation. These runs distinguish modulo wrap from clamping in each direction, and interleaved clears show that the clear comes after the accumulations issued before it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 8;
  parameter int NUM_AR = 8;
  parameter int ACC_W  = 40;
  parameter int NUM_ACC = 2;
  localparam int AR_SEL_W  = $clog2(NUM_AR);
  localparam int ACC_SEL_W = $clog2(NUM_ACC);
  localparam int PROD_W    = 2 * DATA_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MAC  = 3'd1,
    OP_MACN = 3'd2,
    OP_CLR  = 3'd3,
    OP_LDAR = 3'd4
  } op_e;

  // signed product of two data words
  function automatic logic [PROD_W-1:0] mul_signed(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] sa, sb;
    sa = PROD_W'($signed(a));
    sb = PROD_W'($signed(b));
    return sa * sb;
  endfunction

  // one extra bit above the accumulator to see overflow
  function automatic logic [ACC_W:0] mac_wide(input logic [ACC_W-1:0] acc,
                                              input logic [PROD_W-1:0] prod);
    return {acc[ACC_W-1], acc} + {{(ACC_W+1-PROD_W){prod[PROD_W-1]}}, prod};
  endfunction

  function automatic logic mac_ovf(input logic [ACC_W:0] wide);
    return wide[ACC_W] ^ wide[ACC_W-1];
  endfunction

  function automatic logic [ACC_W-1:0] mac_next(input logic [ACC_W-1:0] acc,
                                                input logic [PROD_W-1:0] prod,
                                                input logic sat);
    logic [ACC_W:0] wide;
    wide = mac_wide(acc, prod);
    if (sat && mac_ovf(wide))
      return wide[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    return wide[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/dmac_ar_bank.sv
module dmac_ar_bank
  import dmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 op,
  input  logic [AR_SEL_W-1:0] sel_i,
  input  logic [AR_SEL_W-1:0] sel_j,
  input  logic [ADDR_W-1:0]   imm,
  output logic [ADDR_W-1:0]   addr_i,
  output logic [ADDR_W-1:0]   addr_j
);
  logic [ADDR_W-1:0] ar_q [NUM_AR];
  logic step_en;
  logic load_en;

  assign step_en = (op == OP_MAC);
  assign load_en = (op == OP_LDAR);

  for (genvar k = 0; k < NUM_AR; k++) begin : g_ar
    logic hit_i, hit_j;
    assign hit_i = (sel_i == AR_SEL_W'(k));
    assign hit_j = (sel_j == AR_SEL_W'(k));
    // a register named by both operands still sees one step
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ar_q[k] <= '0;
      else if (load_en && hit_i)          ar_q[k] <= imm;
      else if (step_en && (hit_i || hit_j)) ar_q[k] <= ar_q[k] + ADDR_W'(1);
    end
  end

  assign addr_i = ar_q[sel_i];
  assign addr_j = ar_q[sel_j];

  assert_postinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sel_i != sel_j) |=>
      (ar_q[$past(sel_i)] == $past(ar_q[sel_i]) + ADDR_W'(1)) &&
      (ar_q[$past(sel_j)] == $past(ar_q[sel_j]) + ADDR_W'(1)));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sel_i == sel_j) |=>
      ar_q[$past(sel_i)] == $past(ar_q[sel_i]) + ADDR_W'(1));

  assert_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MACN) |=>
      (ar_q[$past(sel_i)] == $past(ar_q[sel_i])) &&
      (ar_q[$past(sel_j)] == $past(ar_q[sel_j])));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ar_q[$past(sel_i)] == $past(imm));
endmodule

// File: rtl/dmac_mac_unit.sv
module dmac_mac_unit
  import dmac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 clr,
  input  logic [ACC_SEL_W-1:0] acc_sel,
  input  logic                 sat,
  input  logic [DATA_W-1:0]    xd,
  input  logic [DATA_W-1:0]    yd,
  output logic [ACC_W-1:0]     acc_a,
  output logic [ACC_W-1:0]     acc_b
);
  logic [ACC_W-1:0]  acc_q [NUM_ACC];
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_cur;
  logic              ovf;

  assign prod    = mul_signed(xd, yd);
  assign acc_cur = acc_q[acc_sel];
  assign ovf     = fire && mac_ovf(mac_wide(acc_cur, prod));

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic mine;
    assign mine = (acc_sel == ACC_SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              acc_q[g] <= '0;
      else if (clr && mine)    acc_q[g] <= '0;
      else if (fire && mine)   acc_q[g] <= mac_next(acc_q[g], prod, sat);
    end
  end

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];

  assert_other_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || clr) |=> acc_q[~$past(acc_sel)] == $past(acc_q[~acc_sel]));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q[$past(acc_sel)] == '0);

  assert_sat_clamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && sat) |=>
      (acc_q[$past(acc_sel)] == {1'b0, {(ACC_W-1){1'b1}}}) ||
      (acc_q[$past(acc_sel)] == {1'b1, {(ACC_W-1){1'b0}}}));
endmodule

// File: rtl/dmac_core.sv
module dmac_core
  import dmac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_code,
  input  logic [AR_SEL_W-1:0]  op_ari,
  input  logic [AR_SEL_W-1:0]  op_arj,
  input  logic [ACC_SEL_W-1:0] op_acc,
  input  logic [ADDR_W-1:0]    op_imm,
  input  logic                 op_sat,
  output logic [ADDR_W-1:0]    x_addr,
  output logic [ADDR_W-1:0]    y_addr,
  input  logic [DATA_W-1:0]    x_rdata,
  input  logic [DATA_W-1:0]    y_rdata,
  output logic [ACC_W-1:0]     acc_a,
  output logic [ACC_W-1:0]     acc_b
);
  op_e op_d;
  assign op_d = op_e'(op_code);

  // stage 2 carries the accumulate control alongside the memory read
  logic                 s2_fire;
  logic                 s2_clr;
  logic [ACC_SEL_W-1:0] s2_acc;
  logic                 s2_sat;
  logic                 issue_mac;
  logic                 issue_clr;

  assign issue_mac = (op_d == OP_MAC) || (op_d == OP_MACN);
  assign issue_clr = (op_d == OP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_fire <= 1'b0;
      s2_clr  <= 1'b0;
      s2_acc  <= '0;
      s2_sat  <= 1'b0;
    end else begin
      s2_fire <= issue_mac;
      s2_clr  <= issue_clr;
      s2_acc  <= op_acc;
      s2_sat  <= op_sat;
    end
  end

  dmac_ar_bank i_ar_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op_d),
    .sel_i  (op_ari),
    .sel_j  (op_arj),
    .imm    (op_imm),
    .addr_i (x_addr),
    .addr_j (y_addr)
  );

  dmac_mac_unit i_mac_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (s2_fire),
    .clr     (s2_clr),
    .acc_sel (s2_acc),
    .sat     (s2_sat),
    .xd      (x_rdata),
    .yd      (y_rdata),
    .acc_a   (acc_a),
    .acc_b   (acc_b)
  );

  assert_stage_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s2_fire && s2_clr));
endmodule

// File: tb/test_dmac_core.sv
module test_dmac_core;
  localparam int CLK_PERIOD = 10;
  localparam longint ACC_MAX = (64'sd1 <<< 39) - 1;
  localparam longint ACC_MIN = -(64'sd1 <<< 39);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  op_ari = '0;
  logic [2:0]  op_arj = '0;
  logic        op_acc = 1'b0;
  logic [7:0]  op_imm = '0;
  logic        op_sat = 1'b0;
  logic [7:0]  x_addr, y_addr;
  logic [15:0] x_rdata = '0;
  logic [15:0] y_rdata = '0;
  logic [39:0] acc_a, acc_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_ar [8];
  longint     m_acc [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_core i_dmac_core (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_ari(op_ari), .op_arj(op_arj),
    .op_acc(op_acc), .op_imm(op_imm), .op_sat(op_sat), .x_addr(x_addr), .y_addr(y_addr),
    .x_rdata(x_rdata), .y_rdata(y_rdata), .acc_a(acc_a), .acc_b(acc_b)
  );

  function automatic logic [15:0] xval(input logic [7:0] a);
    if (a == 8'hF0) return 16'h8000;
    return {a ^ 8'hA5, a};
  endfunction

  function automatic logic [15:0] yval(input logic [7:0] a);
    if (a == 8'hF0) return 16'h8000;
    if (a == 8'hF1) return 16'h7FFF;
    return 16'(a) * 16'd371 + 16'd7;
  endfunction

  always @(posedge clk) begin
    x_rdata <= xval(x_addr);
    y_rdata <= yval(y_addr);
  end

  function automatic longint sx40(input logic [39:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic do_op(input int op, input int i, input int j, input int acc,
                       input int imm, input bit sat, input string req);
    longint pa, pb, prod, sum;
    op_code = 3'(op); op_ari = 3'(i); op_arj = 3'(j);
    op_acc = acc[0]; op_imm = 8'(imm); op_sat = sat;
    #1;
    chk(x_addr == m_ar[i], "R2", longint'(x_addr), longint'(m_ar[i]));
    chk(y_addr == m_ar[j], "R2", longint'(y_addr), longint'(m_ar[j]));
    pa = m_acc[0]; pb = m_acc[1];
    if (op == 1 || op == 2) begin
      prod = longint'($signed(xval(m_ar[i]))) * longint'($signed(yval(m_ar[j])));
      sum = m_acc[acc] + prod;
      if (sum > ACC_MAX) sum = sat ? ACC_MAX : sum - (64'sd1 <<< 40);
      if (sum < ACC_MIN) sum = sat ? ACC_MIN : sum + (64'sd1 <<< 40);
      m_acc[acc] = sum;
      if (op == 1) begin
        m_ar[i] = m_ar[i] + 8'd1;
        if (j != i) m_ar[j] = m_ar[j] + 8'd1;
      end
    end else if (op == 3) begin
      m_acc[acc] = 0;
    end else if (op == 4) begin
      m_ar[i] = 8'(imm);
    end
    @(negedge clk);
    chk(sx40(acc_a) == pa, req, sx40(acc_a), pa);
    chk(sx40(acc_b) == pb, req, sx40(acc_b), pb);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_ar[k] = '0;
    m_acc[0] = 0; m_acc[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(acc_a == '0, "R1", sx40(acc_a), 0);
    chk(acc_b == '0, "R1", sx40(acc_b), 0);
    for (int k = 0; k < 8; k++) do_op(0, k, 7 - k, 0, 0, 0, "R1");

    // R9: load every address register, also through ignored codes
    for (int k = 0; k < 8; k++) do_op(4, k, k, 0, k * 29 + 3, 0, "R9");
    for (int k = 0; k < 8; k++) do_op(5 + (k % 3), k, 7 - k, k % 2, 200, 1, "R9");

    // R3 R4 R7: stepping MACs past the address wrap, alternating accumulators
    for (int n = 0; n < 300; n++) do_op(1, 0, 1, (n / 3) % 2, 0, 0, "R3");
    do_op(0, 0, 1, 0, 0, 0, "R7");
    chk(x_addr == 8'd47, "R4", longint'(x_addr), 47);

    // R5: one register for both operands
    for (int n = 0; n < 5; n++) do_op(1, 2, 2, 1, 0, 0, "R5");
    do_op(0, 2, 2, 0, 0, 0, "R5");
    chk(x_addr == 8'd66, "R5", longint'(x_addr), 66);

    // R6: no stepping
    for (int n = 0; n < 4; n++) do_op(2, 3, 4, 0, 0, 0, "R6");
    do_op(0, 3, 4, 0, 0, 0, "R6");
    chk(x_addr == 8'd90 && y_addr == 8'd119, "R6", longint'(x_addr), 90);

    // R8: clear right behind an accumulation
    do_op(1, 5, 6, 0, 0, 0, "R8");
    do_op(3, 0, 0, 0, 0, 0, "R8");
    do_op(0, 0, 0, 0, 0, 0, "R8");
    chk(acc_a == '0, "R8", sx40(acc_a), 0);
    chk(acc_b != '0, "R8", sx40(acc_b), m_acc[1]);

    // R10 R11: drive past the accumulator range
    do_op(4, 6, 6, 0, 8'hF0, 0, "R9");
    do_op(4, 7, 7, 0, 8'hF1, 0, "R9");
    do_op(3, 0, 0, 1, 0, 0, "R8");
    for (int n = 0; n < 600; n++) do_op(2, 6, 6, 1, 0, 0, "R10");
    do_op(0, 0, 0, 0, 0, 0, "R10");
    chk(sx40(acc_b) == -424 * (64'sd1 <<< 30), "R10", sx40(acc_b), -424 * (64'sd1 <<< 30));
    for (int n = 0; n < 600; n++) do_op(2, 6, 6, 0, 0, 1, "R11");
    do_op(0, 0, 0, 0, 0, 0, "R11");
    chk(sx40(acc_a) == ACC_MAX, "R11", sx40(acc_a), ACC_MAX);
    do_op(3, 0, 0, 0, 0, 0, "R8");
    for (int n = 0; n < 600; n++) do_op(2, 6, 7, 0, 0, 1, "R11");
    do_op(0, 0, 0, 0, 0, 0, "R11");
    chk(sx40(acc_a) == ACC_MIN, "R11", sx40(acc_a), ACC_MIN);

    finish_run();
  end
endmodule